// File: doc/BRIEF.md
# Continuous Frame Replay Transmitter

This block is a production-test controller for a radio transmit path. Once armed, it either replays the payload of a frame held in a byte-addressed buffer as an unbroken byte stream, or it holds the transmitter on a continuous tone placed half a megahertz above or below the channel centre. In replay mode it first reads the length byte at buffer address 0. It then streams payload bytes 1 through N on a valid/ready interface, and after byte N it returns to byte 1 with no gap. The sync header and the length byte never appear on the stream.

Software chooses the mode, and optionally the channel and power, before arming. Arming takes two register accesses in a fixed order: first the test-control address, then the identification address. Any other access between them cancels the sequence. Setting the mode to off, or asserting reset, ends the test. The stream then stops on a whole-byte boundary and every byte still queued is discarded. A length byte outside 1..127 raises an error flag, and the controller stays idle.

Top module: `frame_loop_tx`

## Requirements
- R1: After reset, txValid, toneEn and lenErr are 0.
- R2: Test mode starts only when an access to address TESTCTL_ADDR (default 8'h36) is immediately followed, as the next access, by an access to IDREG_ADDR (default 8'h1C). The reverse order, or any other access between the two, starts nothing.
- R3: If cfgMode is off (2'b00) when the arming sequence completes, nothing starts: no stream, no tone.
- R4: In replay mode (cfgMode 2'b01), the byte at buffer address 0 is the length N. The stream carries the bytes at addresses 1..N in order and never carries the length byte.
- R5: After address N the stream continues at address 1. With txReady held high, txValid stays high on every cycle from the first byte onward, including across the wrap.
- R6: A length byte of 0 or above 127 sets lenErr, and no stream or tone follows. The next arming with a mode other than off clears lenErr.
- R7: cfgMode 2'b10 drives toneEn=1 with toneOffsetHigh=1 (centre +0.5 MHz). cfgMode 2'b11 drives toneEn=1 with toneOffsetHigh=0 (centre −0.5 MHz). No stream bytes are sent in either tone mode.
- R8: While txValid is 1 and txReady is 0, txValid stays 1 and txData holds its value.
- R9: Setting cfgMode to off stops the test: txValid and toneEn are 0 within two cycles. The next replay arming starts again from address 1.
- R10: cfgChannel and cfgPower are captured when arming completes and appear on txChannel and txPower. They stay unchanged while the test runs, even if the configuration inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAcc | input | 1 | Register access strobe |
| regAddr | input | REG_AW | Register access address |
| cfgMode | input | 2 | 00 off, 01 replay, 10 tone high, 11 tone low |
| cfgChannel | input | CH_W | Channel setting |
| cfgPower | input | PWR_W | Output power setting |
| bufAddr | output | BUF_AW | Frame buffer read address |
| bufData | input | DATA_W | Frame buffer read data, one cycle after address |
| txData | output | DATA_W | Stream byte |
| txValid | output | 1 | Stream byte valid |
| txReady | input | 1 | Stream consumer ready |
| toneEn | output | 1 | Continuous tone enable |
| toneOffsetHigh | output | 1 | 1 selects +0.5 MHz, 0 selects −0.5 MHz |
| txChannel | output | CH_W | Channel captured at arming |
| txPower | output | PWR_W | Power captured at arming |
| lenErr | output | 1 | Invalid length byte seen |

## Verification
Two events can land on the same edge: the wrap from address N back to 1, and a stall or release of txReady. Both touch the prefetch queue and the read pointer together. The bench runs lengths 1, 2 and 127 along with random lengths, and drives txReady with random patterns. Every accepted byte is compared with a model of the buffer walked modulo N. Every stalled byte must still be present, unchanged, on the next cycle. A second overlap is a mode clear arriving while a buffer read is in flight. This is judged by requiring txValid to be low two cycles later, and by checking that a re-arm starts again at address 1.

// File: rtl/frame_loop_pkg.sv
package frame_loop_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_REPLAY  = 2'b01,
    MODE_TONE_HI = 2'b10,
    MODE_TONE_LO = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN_REQ,
    ST_LEN_CHK,
    ST_REPLAY,
    ST_TONE
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic lenReq;   // drive address 0 to fetch length byte
    logic lenLoad;  // capture length, restart pointer at 1
    logic run;      // fetch payload bytes
    logic flush;    // drop queue and in-flight read
  } dpCtrl_t;

endpackage

// File: rtl/frame_loop_ctrl.sv
module frame_loop_ctrl
  import frame_loop_pkg::*;
#(
  parameter int REG_AW       = 8,
  parameter int DATA_W       = 8,
  parameter int CH_W         = 5,
  parameter int PWR_W        = 4,
  parameter int MAX_LEN      = 127,
  parameter logic [REG_AW-1:0] TESTCTL_ADDR = 8'h36,
  parameter logic [REG_AW-1:0] IDREG_ADDR   = 8'h1C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regAcc,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [1:0]        cfgMode,
  input  logic [CH_W-1:0]   cfgChannel,
  input  logic [PWR_W-1:0]  cfgPower,
  input  logic [DATA_W-1:0] bufData,
  output dpCtrl_t           ctl,
  output logic              toneEn,
  output logic              toneOffsetHigh,
  output logic [CH_W-1:0]   txChannel,
  output logic [PWR_W-1:0]  txPower,
  output logic              lenErr
);

  localparam logic [DATA_W-1:0] LEN_LIMIT = DATA_W'(MAX_LEN);

  state_e state, stateNext;
  mode_e  mode;
  logic   armStage;
  logic   armHit;
  logic   modeOff;
  logic   lenBad;
  logic   startNow;

  assign mode     = mode_e'(cfgMode);
  assign modeOff  = (mode == MODE_OFF);
  assign armHit   = regAcc && armStage && (regAddr == IDREG_ADDR);
  assign lenBad   = (bufData == '0) || (bufData > LEN_LIMIT);
  assign startNow = (state == ST_IDLE) && armHit && !modeOff;

  // arming sequencer: any access other than the test-control address
  // drops a pending first step
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armStage <= 1'b0;
    end else if (regAcc) begin
      armStage <= (regAddr == TESTCTL_ADDR);
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (startNow) begin
          stateNext = (mode == MODE_REPLAY) ? ST_LEN_REQ : ST_TONE;
        end
      end
      ST_LEN_REQ: stateNext = modeOff ? ST_IDLE : ST_LEN_CHK;
      ST_LEN_CHK: stateNext = (modeOff || lenBad) ? ST_IDLE : ST_REPLAY;
      ST_REPLAY:  stateNext = modeOff ? ST_IDLE : ST_REPLAY;
      ST_TONE:    stateNext = modeOff ? ST_IDLE : ST_TONE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      lenErr         <= 1'b0;
      toneOffsetHigh <= 1'b0;
      txChannel      <= '0;
      txPower        <= '0;
    end else begin
      state <= stateNext;
      if (startNow) begin
        lenErr         <= 1'b0;
        toneOffsetHigh <= (mode == MODE_TONE_HI);
        txChannel      <= cfgChannel;
        txPower        <= cfgPower;
      end else if (state == ST_LEN_CHK && !modeOff && lenBad) begin
        lenErr <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl.lenReq  = (state == ST_LEN_REQ);
    ctl.lenLoad = (state == ST_LEN_CHK) && !modeOff && !lenBad;
    ctl.run     = (state == ST_REPLAY) && !modeOff;
    ctl.flush   = (state != ST_REPLAY) || modeOff;
  end

  assign toneEn = (state == ST_TONE);

  // mode clear always returns to idle on the next edge
  p_stop_on_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && modeOff) |=> (state == ST_IDLE));

  // an error flag only coexists with idle
  p_err_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |-> (state == ST_IDLE));

  // captured settings do not move while a test is active
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_REPLAY || state == ST_TONE) && !modeOff)
      |=> ($stable(txChannel) && $stable(txPower)));

  // a tone never starts without a completed arming sequence
  p_tone_needs_arm_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(toneEn)) |-> $past(armHit));

endmodule

// File: rtl/frame_loop_dp.sv
module frame_loop_dp
  import frame_loop_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 127,
  localparam int BUF_AW = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  output logic [BUF_AW-1:0] bufAddr,
  input  logic [DATA_W-1:0] bufData,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady
);

  logic [DATA_W-1:0] len;
  logic [BUF_AW-1:0] ptr;
  logic [DATA_W-1:0] ptrExt;
  logic              ptrWrap;
  logic              rdPending;
  logic [1:0]        count;
  logic [DATA_W-1:0] headQ;
  logic [DATA_W-1:0] tailQ;
  logic              pop;
  logic              push;
  logic [2:0]        occAfter;
  logic              issue;

  assign ptrExt   = DATA_W'(ptr);
  assign ptrWrap  = (ptrExt == len);
  assign pop      = txValid && txReady;
  assign push     = rdPending && !ctl.flush;
  assign occAfter = 3'(count) + 3'(rdPending) - 3'(pop);
  assign issue    = ctl.run && (occAfter < 3'd2);
  assign bufAddr  = ctl.lenReq ? '0 : ptr;
  assign txData   = headQ;
  assign txValid  = (count != 2'd0);

  // read pointer and length
  always_ff @(posedge clk) begin
    if (!rstN) begin
      len       <= '0;
      ptr       <= BUF_AW'(1);
      rdPending <= 1'b0;
    end else begin
      rdPending <= issue;
      if (ctl.lenLoad) begin
        len <= bufData;
        ptr <= BUF_AW'(1);
      end else if (issue) begin
        ptr <= ptrWrap ? BUF_AW'(1) : ptr + BUF_AW'(1);
      end
    end
  end

  // two-entry prefetch queue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= 2'd0;
      headQ <= '0;
      tailQ <= '0;
    end else if (ctl.flush) begin
      count <= 2'd0;
    end else begin
      unique case ({push, pop})
        2'b10: begin
          if (count == 2'd0) headQ <= bufData;
          else               tailQ <= bufData;
          count <= count + 2'd1;
        end
        2'b01: begin
          headQ <= tailQ;
          count <= count - 2'd1;
        end
        2'b11: begin
          if (count == 2'd1) begin
            headQ <= bufData;
          end else begin
            headQ <= tailQ;
            tailQ <= bufData;
          end
        end
        default: ;
      endcase
    end
  end

  p_read_in_frame_r4: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> (ptr != '0 && ptrExt <= len));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |-> (count < 2'd2));

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !ctl.flush) |=> (txValid && $stable(txData)));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> !txValid);

endmodule

// File: rtl/frame_loop_tx.sv
module frame_loop_tx
  import frame_loop_pkg::*;
#(
  parameter int REG_AW       = 8,
  parameter int DATA_W       = 8,
  parameter int CH_W         = 5,
  parameter int PWR_W        = 4,
  parameter int MAX_LEN      = 127,
  parameter logic [REG_AW-1:0] TESTCTL_ADDR = 8'h36,
  parameter logic [REG_AW-1:0] IDREG_ADDR   = 8'h1C,
  localparam int BUF_AW = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regAcc,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [1:0]        cfgMode,
  input  logic [CH_W-1:0]   cfgChannel,
  input  logic [PWR_W-1:0]  cfgPower,
  output logic [BUF_AW-1:0] bufAddr,
  input  logic [DATA_W-1:0] bufData,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              toneEn,
  output logic              toneOffsetHigh,
  output logic [CH_W-1:0]   txChannel,
  output logic [PWR_W-1:0]  txPower,
  output logic              lenErr
);

  dpCtrl_t ctl;

  frame_loop_ctrl #(
    .REG_AW(REG_AW), .DATA_W(DATA_W), .CH_W(CH_W), .PWR_W(PWR_W),
    .MAX_LEN(MAX_LEN), .TESTCTL_ADDR(TESTCTL_ADDR), .IDREG_ADDR(IDREG_ADDR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .regAcc(regAcc), .regAddr(regAddr),
    .cfgMode(cfgMode), .cfgChannel(cfgChannel), .cfgPower(cfgPower),
    .bufData(bufData), .ctl(ctl), .toneEn(toneEn),
    .toneOffsetHigh(toneOffsetHigh), .txChannel(txChannel),
    .txPower(txPower), .lenErr(lenErr)
  );

  frame_loop_dp #(
    .DATA_W(DATA_W), .MAX_LEN(MAX_LEN)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bufAddr(bufAddr),
    .bufData(bufData), .txData(txData), .txValid(txValid),
    .txReady(txReady)
  );

  p_tone_or_stream_r7: assert property (@(posedge clk) disable iff (!rstN)
    toneEn |-> !txValid);

endmodule

// File: tb/test_frame_loop_tx.sv
module test_frame_loop_tx;

  localparam logic [7:0] TCTL  = 8'h36;
  localparam logic [7:0] IDR   = 8'h1C;
  localparam logic [7:0] OTHER = 8'h05;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regAcc = 1'b0;
  logic [7:0] regAddr = '0;
  logic [1:0] cfgMode = 2'b00;
  logic [4:0] cfgChannel = 5'd11;
  logic [3:0] cfgPower = 4'd3;
  logic [6:0] bufAddr;
  logic [7:0] bufData;
  logic [7:0] txData;
  logic       txValid;
  logic       txReady = 1'b0;
  logic       toneEn;
  logic       toneOffsetHigh;
  logic [4:0] txChannel;
  logic [3:0] txPower;
  logic       lenErr;

  logic [7:0] mem [0:127];
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) bufData <= mem[bufAddr];

  frame_loop_tx i_frame_loop_tx (
    .clk(clk), .rstN(rstN), .regAcc(regAcc), .regAddr(regAddr),
    .cfgMode(cfgMode), .cfgChannel(cfgChannel), .cfgPower(cfgPower),
    .bufAddr(bufAddr), .bufData(bufData), .txData(txData),
    .txValid(txValid), .txReady(txReady), .toneEn(toneEn),
    .toneOffsetHigh(toneOffsetHigh), .txChannel(txChannel),
    .txPower(txPower), .lenErr(lenErr)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, act=%0d exp<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int nextIdx(input int idx, input int len);
    return (idx == len) ? 1 : idx + 1;
  endfunction

  task automatic access(input logic [7:0] a);
    @(negedge clk); regAcc = 1'b1; regAddr = a;
    @(negedge clk); regAcc = 1'b0;
  endtask

  task automatic arm();
    access(TCTL);
    access(IDR);
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fillBuf(input int len);
    mem[0] = 8'(len);
    for (int i = 1; i < 128; i++) mem[i] = 8'($urandom);
  endtask

  task automatic stopTest();
    @(negedge clk); cfgMode = 2'b00; txReady = 1'b0;
    waitCyc(2);
    chk(!txValid && !toneEn, "R9 stop", int'(txValid | toneEn), 0);
  endtask

  // replay N bytes and compare against buffer walked modulo len
  task automatic runReplay(input int len, input int nBytes, input bit randReady);
    int idx = 1;
    int got = 0;
    int gaps = 0;
    int limit = 30 * nBytes + 60;
    bit seen = 0;
    bit holdPend = 0;
    logic [7:0] holdData = '0;
    logic [4:0] ch0;
    fillBuf(len);
    cfgMode = 2'b01;
    arm();
    ch0 = txChannel;
    cfgChannel = cfgChannel + 5'd7;
    for (int c = 0; c < limit && got < nBytes; c++) begin
      @(negedge clk);
      txReady = randReady ? (($urandom % 4) != 0) : 1'b1;
      #1;
      if (holdPend) begin
        chk(txValid && txData == holdData, "R8 stall hold", int'(txData), int'(holdData));
        holdPend = 0;
      end
      if (txValid) begin
        seen = 1;
        if (txReady) begin
          chk(txData == mem[idx], "R4 R5 byte order", int'(txData), int'(mem[idx]));
          idx = nextIdx(idx, len);
          got++;
        end else begin
          holdPend = 1;
          holdData = txData;
        end
      end else if (seen && !randReady) begin
        gaps++;
      end
    end
    chk(got == nBytes, "R4 byte count", got, nBytes);
    if (!randReady) chk(gaps == 0, "R5 no gap on wrap", gaps, 0);
    chk(txChannel == ch0, "R10 channel held", int'(txChannel), int'(ch0));
    chk(!lenErr, "R6 err cleared", int'(lenErr), 0);
    stopTest();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'd0;
    void'($urandom(32'h5EED_0042));
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    chk(!txValid && !toneEn && !lenErr, "R1 reset", int'({txValid, toneEn, lenErr}), 0);

    // R2 wrong order and interleaved access
    fillBuf(5);
    cfgMode = 2'b01;
    access(IDR); access(TCTL);
    waitCyc(8);
    chk(!txValid, "R2 reverse order", int'(txValid), 0);
    access(OTHER);
    access(TCTL); access(OTHER); access(IDR);
    waitCyc(8);
    chk(!txValid && !toneEn, "R2 interleaved", int'(txValid), 0);

    // R3 mode off at arming
    cfgMode = 2'b00;
    arm();
    waitCyc(8);
    chk(!txValid && !toneEn, "R3 mode off", int'({txValid, toneEn}), 0);

    // R6 invalid lengths
    mem[0] = 8'd0; cfgMode = 2'b01; txReady = 1'b1;
    arm(); waitCyc(6);
    chk(lenErr && !txValid, "R6 zero length", int'({lenErr, txValid}), 2);
    mem[0] = 8'd200;
    arm(); waitCyc(6);
    chk(lenErr && !txValid, "R6 length 200", int'({lenErr, txValid}), 2);
    mem[0] = 8'd128;
    arm(); waitCyc(6);
    chk(lenErr && !txValid, "R6 length 128", int'({lenErr, txValid}), 2);
    cfgMode = 2'b00;

    // directed lengths, full rate then stalls
    runReplay(1, 20, 1'b0);
    runReplay(2, 21, 1'b0);
    runReplay(127, 300, 1'b0);
    runReplay(127, 300, 1'b1);
    runReplay(3, 40, 1'b1);

    // R7 tone modes
    cfgMode = 2'b10; cfgPower = 4'd9;
    arm(); waitCyc(2);
    chk(toneEn && toneOffsetHigh && !txValid, "R7 tone high",
        int'({toneEn, toneOffsetHigh, txValid}), 6);
    chk(txPower == 4'd9, "R10 power captured", int'(txPower), 9);
    cfgPower = 4'd1; waitCyc(3);
    chk(txPower == 4'd9, "R10 power held", int'(txPower), 9);
    stopTest();
    cfgMode = 2'b11;
    arm(); waitCyc(2);
    chk(toneEn && !toneOffsetHigh && !txValid, "R7 tone low",
        int'({toneEn, toneOffsetHigh, txValid}), 4);
    stopTest();

    // R9 re-arm restarts from first payload byte after mid-stream stop
    fillBuf(9);
    cfgMode = 2'b01; txReady = 1'b1;
    arm(); waitCyc(10);
    stopTest();
    cfgMode = 2'b01; txReady = 1'b1;
    arm();
    for (int c = 0; c < 20 && !txValid; c++) begin
      @(negedge clk); #1;
    end
    chk(txValid && txData == mem[1], "R9 restart at first byte", int'(txData), int'(mem[1]));
    stopTest();

    // random lengths with random stalls
    for (int k = 0; k < 8; k++) begin
      runReplay(1 + int'($urandom % 127), 150, 1'($urandom % 2));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule